// File: doc/BRIEF.md
# Clock-Synchronous Peripheral Cycle Bridge

This bridge lets a bus master that normally ends each cycle with a handshake reach slow peripherals that have to be clocked from one shared phase clock. The bridge divides the system clock by ten to make that phase clock, which runs freely whether or not a cycle is in progress. When the master opens a cycle with its strobe and the address decoder answers with the slow-peripheral select in place of the usual acknowledge, the bridge takes over the timing of the cycle.

After a fixed recognition delay the bridge waits for the phase clock to be low and then asserts an active-low chip select toward the peripheral. The peripheral moves data while the phase clock is high. On the falling edge of the phase clock the bridge captures read data, drops the chip select and pulses a completion signal, and the master then releases its strobe. A sticky flag reports two select-line protocol violations.

Top module: `sync_periph_bridge`

## Requirements
- R1: `phase_clk` is a free-running divide-by-10 of `clk`: after reset it is low for the first 6 clock edges and then repeats high for 4 edges, low for 6 edges. Edge n after reset (n = 1, 2, ...) samples `phase_clk` high when (n-1) mod 10 is 6 or more.
- R2: While `rst_n` is low and just after it: `phase_clk` = 0, `per_cs_n` = 1, `cyc_done` = 0, `rd_valid` = 0, `per_doe` = 0, `rd_data` = 0, `proto_err` = 0.
- R3: If `strb_n` is first sampled low at edge k and `slow_sel_n` is first sampled low at edge k+d, the cycle is recognised at edge r = k + max(3, d).
- R4: `per_cs_n` goes low after the first edge m > r at which `phase_clk` is sampled low, and it is only ever low while the strobe was low at the edge before.
- R5: At the first edge c > m where (c-1) mod 10 = 9 (the last high edge of `phase_clk`), `per_cs_n` returns high and `cyc_done` is high for exactly the one following cycle.
- R6: On a read (`rd_wr` = 1 at the start of the cycle), `rd_data` is loaded at edge c from `per_din`, byte lane i taken only when `lane_n[i]` = 0 (lane 1 is bits 15:8, lane 0 is bits 7:0) and zero otherwise; `rd_valid` pulses with `cyc_done`. A write leaves `rd_data` unchanged and `rd_valid` low.
- R7: On a write (`rd_wr` = 0), `per_doe` is high and `per_dout` equals `wr_data` from the cycle `per_cs_n` goes low through the `cyc_done` cycle, and low otherwise.
- R8: If `strb_n` rises before recognition, no chip select and no completion follow.
- R9: `fast_ack_n` and `slow_sel_n` both sampled low at one edge sets `proto_err` from the next cycle.
- R10: `slow_sel_n` sampled low at an edge where `strb_n` is sampled high at that edge and the edge before sets `proto_err`; dropping the select one clock after the strobe rises does not.
- R11: `proto_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strb_n | input | 1 | Master cycle strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| lane_n | input | 2 | Byte lane strobes, active low, lane 1 = upper byte |
| slow_sel_n | input | 1 | Slow-peripheral select from address decode, active low |
| fast_ack_n | input | 1 | Normal acknowledge, watched for protocol errors |
| wr_data | input | 16 | Master write data |
| per_din | input | 16 | Read data from the peripheral |
| phase_clk | output | 1 | Divide-by-10 phase clock |
| per_cs_n | output | 1 | Peripheral chip select, active low |
| per_dout | output | 16 | Write data toward the peripheral |
| per_doe | output | 1 | Write data drive enable |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | Read capture pulse |
| cyc_done | output | 1 | Cycle completion pulse |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
On every cycle the assertions hold the phase clock to its 4-high, 6-low shape, keep the chip select from falling while the phase clock is high or persisting without a strobe, tie completion to a phase-clock fall as a single pulse, keep the write drive inside the select window and keep the error flag sticky. Only the bench scenarios can show the exact edge of recognition for each select delay, the lane masking of captured data, the unchanged read register after writes, the aborted cycle and the one-clock grace on select release, since these need the expected edge numbers and data computed from the stimulus.

// File: rtl/spb_pkg.sv
package spb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_ALIGN,
    ST_XFER,
    ST_FIN
  } cyc_state_t;

  // phase clock is high in the last HI counts of each DIV-long period
  function automatic logic phase_high(int unsigned cnt, int unsigned div, int unsigned hi);
    return cnt >= (div - hi);
  endfunction

  function automatic logic phase_end(int unsigned cnt, int unsigned div);
    return cnt == (div - 1);
  endfunction

endpackage

// File: rtl/spb_phase_gen.sv
module spb_phase_gen
  import spb_pkg::*;
#(
  parameter int unsigned DIV = 10,
  parameter int unsigned HI  = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_clk,
  output logic phase_last
);
  localparam int unsigned CW = $clog2(DIV);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (phase_end(32'(cnt), DIV)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign phase_clk  = phase_high(32'(cnt), DIV, HI);
  assign phase_last = phase_end(32'(cnt), DIV);

endmodule

// File: rtl/spb_cycle_ctl.sv
module spb_cycle_ctl
  import spb_pkg::*;
#(
  parameter int unsigned REC_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  input  logic slow_sel_n,
  input  logic phase_clk,
  input  logic phase_last,
  output logic per_cs_n,
  output logic cyc_done,
  output logic in_xfer,
  output logic ev_start,
  output logic ev_arm,
  output logic ev_capture
);
  localparam int unsigned DCW = $clog2(REC_DLY + 1);

  cyc_state_t     st;
  logic [DCW-1:0] dly;
  logic           ev_recog;

  assign ev_start   = (st == ST_IDLE)  && !strb_n;
  assign ev_recog   = (st == ST_SYNC)  && !strb_n && (dly == DCW'(REC_DLY)) && !slow_sel_n;
  assign ev_arm     = (st == ST_ALIGN) && !strb_n && !phase_clk;
  assign ev_capture = (st == ST_XFER)  && !strb_n && phase_last;
  assign in_xfer    = (st == ST_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      dly      <= '0;
      per_cs_n <= 1'b1;
      cyc_done <= 1'b0;
    end else begin
      cyc_done <= ev_capture;
      case (st)
        ST_IDLE: begin
          if (ev_start) begin
            st  <= ST_SYNC;
            dly <= DCW'(1);
          end
        end
        ST_SYNC: begin
          if (strb_n) begin
            st <= ST_IDLE;
          end else if (dly != DCW'(REC_DLY)) begin
            dly <= dly + DCW'(1);
          end else if (ev_recog) begin
            st <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (strb_n) begin
            st <= ST_IDLE;
          end else if (ev_arm) begin
            st       <= ST_XFER;
            per_cs_n <= 1'b0;
          end
        end
        ST_XFER: begin
          if (strb_n) begin
            st       <= ST_IDLE;
            per_cs_n <= 1'b1;
          end else if (ev_capture) begin
            st       <= ST_FIN;
            per_cs_n <= 1'b1;
          end
        end
        ST_FIN: begin
          if (strb_n) begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spb_datapath.sv
module spb_datapath #(
  parameter int unsigned DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_start,
  input  logic            ev_arm,
  input  logic            ev_capture,
  input  logic            in_xfer,
  input  logic            cyc_done,
  input  logic            rd_wr,
  input  logic [DW/8-1:0] lane_n,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW-1:0]   per_din,
  output logic [DW-1:0]   per_dout,
  output logic            per_doe,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid
);
  localparam int unsigned LANES = DW / 8;

  logic            rw_q;
  logic [LANES-1:0] lane_q;
  logic [DW-1:0]   wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q     <= 1'b1;
      lane_q   <= '1;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= ev_capture && rw_q;
      if (ev_start) begin
        rw_q   <= rd_wr;
        lane_q <= lane_n;
      end
      if (ev_arm) begin
        wdata_q <= wr_data;
      end
    end
  end

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    logic [7:0] lane_byte;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_byte <= '0;
      end else if (ev_capture && rw_q) begin
        lane_byte <= lane_q[gl] ? 8'h00 : per_din[gl*8 +: 8];
      end
    end
    assign rd_data[gl*8 +: 8] = lane_byte;
  end

  assign per_dout = wdata_q;
  assign per_doe  = !rw_q && (in_xfer || cyc_done);

endmodule

// File: rtl/spb_proto_mon.sv
module spb_proto_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  input  logic slow_sel_n,
  input  logic fast_ack_n,
  output logic proto_err
);
  logic strb_prev;
  logic ack_clash;
  logic late_release;

  assign ack_clash    = !fast_ack_n && !slow_sel_n;
  assign late_release = strb_n && strb_prev && !slow_sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_prev <= 1'b1;
      proto_err <= 1'b0;
    end else begin
      strb_prev <= strb_n;
      if (ack_clash || late_release) begin
        proto_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sync_periph_bridge.sv
module sync_periph_bridge #(
  parameter int unsigned DW      = 16,
  parameter int unsigned DIV     = 10,
  parameter int unsigned HI      = 4,
  parameter int unsigned REC_DLY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strb_n,
  input  logic            rd_wr,
  input  logic [DW/8-1:0] lane_n,
  input  logic            slow_sel_n,
  input  logic            fast_ack_n,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW-1:0]   per_din,
  output logic            phase_clk,
  output logic            per_cs_n,
  output logic [DW-1:0]   per_dout,
  output logic            per_doe,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            cyc_done,
  output logic            proto_err
);
  logic phase_last;
  logic in_xfer;
  logic ev_start;
  logic ev_arm;
  logic ev_capture;

  spb_phase_gen #(.DIV(DIV), .HI(HI)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_clk  (phase_clk),
    .phase_last (phase_last)
  );

  spb_cycle_ctl #(.REC_DLY(REC_DLY)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_n     (strb_n),
    .slow_sel_n (slow_sel_n),
    .phase_clk  (phase_clk),
    .phase_last (phase_last),
    .per_cs_n   (per_cs_n),
    .cyc_done   (cyc_done),
    .in_xfer    (in_xfer),
    .ev_start   (ev_start),
    .ev_arm     (ev_arm),
    .ev_capture (ev_capture)
  );

  spb_datapath #(.DW(DW)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_start   (ev_start),
    .ev_arm     (ev_arm),
    .ev_capture (ev_capture),
    .in_xfer    (in_xfer),
    .cyc_done   (cyc_done),
    .rd_wr      (rd_wr),
    .lane_n     (lane_n),
    .wr_data    (wr_data),
    .per_din    (per_din),
    .per_dout   (per_dout),
    .per_doe    (per_doe),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  spb_proto_mon u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_n     (strb_n),
    .slow_sel_n (slow_sel_n),
    .fast_ack_n (fast_ack_n),
    .proto_err  (proto_err)
  );

endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
  parameter int unsigned DIV = 10,
  parameter int unsigned HI  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic strb_n,
  input logic slow_sel_n,
  input logic fast_ack_n,
  input logic phase_clk,
  input logic per_cs_n,
  input logic per_doe,
  input logic cyc_done,
  input logic rd_valid,
  input logic proto_err
);
  int unsigned hi_run;
  int unsigned lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= 0;
      lo_run <= 0;
    end else if (phase_clk) begin
      hi_run <= hi_run + 1;
      lo_run <= 0;
    end else begin
      lo_run <= lo_run + 1;
      hi_run <= 0;
    end
  end

  assert_phase_high_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_clk) |-> hi_run == HI);
  assert_phase_low_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_clk) |-> lo_run == DIV - HI);
  assert_cs_falls_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_cs_n) |-> !$past(phase_clk));
  assert_cs_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !per_cs_n |-> !$past(strb_n));
  assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (!phase_clk && $past(phase_clk)));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done);
  assert_valid_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> cyc_done);
  assert_drive_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    per_doe |-> (!per_cs_n || cyc_done));
  assert_ack_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fast_ack_n && !slow_sel_n) |=> proto_err);
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind sync_periph_bridge spb_checker #(.DIV(DIV), .HI(HI)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strb_n     (strb_n),
  .slow_sel_n (slow_sel_n),
  .fast_ack_n (fast_ack_n),
  .phase_clk  (phase_clk),
  .per_cs_n   (per_cs_n),
  .per_doe    (per_doe),
  .cyc_done   (cyc_done),
  .rd_valid   (rd_valid),
  .proto_err  (proto_err)
);

// File: tb/sync_periph_bridge_tb.sv
module sync_periph_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 10;
  localparam int HI  = 4;
  localparam int REC = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strb_n = 1'b1;
  logic        rd_wr = 1'b1;
  logic [1:0]  lane_n = 2'b11;
  logic        slow_sel_n = 1'b1;
  logic        fast_ack_n = 1'b1;
  logic [15:0] wr_data = '0;
  logic [15:0] per_din = '0;
  logic        phase_clk, per_cs_n, per_doe, rd_valid, cyc_done, proto_err;
  logic [15:0] per_dout, rd_data;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  int wd_cnt = 0;
  logic [15:0] exp_rd = '0;

  sync_periph_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .strb_n(strb_n), .rd_wr(rd_wr), .lane_n(lane_n),
    .slow_sel_n(slow_sel_n), .fast_ack_n(fast_ack_n), .wr_data(wr_data),
    .per_din(per_din), .phase_clk(phase_clk), .per_cs_n(per_cs_n),
    .per_dout(per_dout), .per_doe(per_doe), .rd_data(rd_data),
    .rd_valid(rd_valid), .cyc_done(cyc_done), .proto_err(proto_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_n <= 0;
    else        edge_n <= edge_n + 1;
  end

  always @(posedge clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", wd_cnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_arm(int r);
    int m = r + 1;
    while (((m - 1) % DIV) >= DIV - HI) m++;
    return m;
  endfunction

  function automatic int exp_cap(int m);
    int c = m + 1;
    while (((c - 1) % DIV) != DIV - 1) c++;
    return c;
  endfunction

  function automatic logic [15:0] exp_read(logic [15:0] pd, logic [1:0] ln);
    return {ln[1] ? 8'h00 : pd[15:8], ln[0] ? 8'h00 : pd[7:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; strb_n = 1'b1; slow_sel_n = 1'b1; fast_ack_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_rd = '0;
  endtask

  task automatic run_cycle(input bit rd, input logic [1:0] ln, input logic [15:0] wd,
                           input logic [15:0] pd, input int d);
    int k, m_seen, c_seen, m_exp, c_exp;
    logic rv_done, oe_done;
    @(negedge clk);
    k = edge_n + 1;
    strb_n = 1'b0; rd_wr = rd; lane_n = ln; wr_data = wd; per_din = pd;
    if (d == 0) slow_sel_n = 1'b0;
    m_exp = exp_arm(k + ((d > REC) ? d : REC));
    c_exp = exp_cap(m_exp);
    m_seen = -1; c_seen = -1; rv_done = 1'b0; oe_done = 1'b0;
    for (int i = 0; i < 80 && c_seen < 0; i++) begin
      @(negedge clk);
      if (m_seen < 0 && !per_cs_n) begin
        m_seen = edge_n;
        if (!rd) begin
          check(per_doe == 1'b1, "R7 drive at select", per_doe, 1);
          check(per_dout == wd, "R7 write data", per_dout, wd);
        end
      end
      if (cyc_done) begin
        c_seen = edge_n; rv_done = rd_valid; oe_done = per_doe;
      end
      if (slow_sel_n && (edge_n + 1 >= k + d)) slow_sel_n = 1'b0;
    end
    check(m_seen == m_exp, "R3/R4 select edge", m_seen, m_exp);
    check(c_seen == c_exp, "R5 completion edge", c_seen, c_exp);
    if (rd) begin
      exp_rd = exp_read(pd, ln);
      check(rd_data == exp_rd, "R6 read capture", rd_data, exp_rd);
      check(rv_done == 1'b1, "R6 read valid", rv_done, 1);
    end else begin
      check(rd_data == exp_rd, "R6 write keeps read data", rd_data, exp_rd);
      check(rv_done == 1'b0, "R6 no valid on write", rv_done, 0);
      check(oe_done == 1'b1, "R7 drive in done cycle", oe_done, 1);
    end
    strb_n = 1'b1; slow_sel_n = 1'b1;
    @(negedge clk);
    check(per_doe == 1'b0, "R7 drive off after done", per_doe, 0);
    check(cyc_done == 1'b0, "R5 single done pulse", cyc_done, 0);
  endtask

  initial begin
    int hi_cnt, lo_cnt, bad_phase;
    bit seen_cs, seen_done;
    void'($urandom(32'd2718));
    // R2 reset values
    #(CLK_PERIOD * 2);
    check(phase_clk == 0, "R2 phase_clk", phase_clk, 0);
    check(per_cs_n == 1, "R2 per_cs_n", per_cs_n, 1);
    check(cyc_done == 0 && rd_valid == 0, "R2 pulses", {cyc_done, rd_valid}, 0);
    check(per_doe == 0, "R2 per_doe", per_doe, 0);
    check(rd_data == 0, "R2 rd_data", rd_data, 0);
    check(proto_err == 0, "R2 proto_err", proto_err, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 phase clock shape over 40 edges
    bad_phase = 0; hi_cnt = 0; lo_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk);
      if (phase_clk != (((edge_n) % DIV) >= DIV - HI)) bad_phase++;
      if (phase_clk) hi_cnt++; else lo_cnt++;
    end
    check(bad_phase == 0, "R1 phase pattern", bad_phase, 0);
    check(hi_cnt == 16 && lo_cnt == 24, "R1 duty", hi_cnt, 16);

    // directed corner cases: earliest select, late select, each lane
    run_cycle(1'b1, 2'b00, 16'h0, 16'hA55A, 0);
    run_cycle(1'b1, 2'b01, 16'h0, 16'h1234, 5);
    run_cycle(1'b1, 2'b10, 16'h0, 16'hBEEF, 3);
    run_cycle(1'b0, 2'b00, 16'hC0DE, 16'hFFFF, 1);
    run_cycle(1'b0, 2'b10, 16'h00F1, 16'h0000, 8);

    // random mix
    for (int n = 0; n < 24; n++) begin
      int l;
      logic [1:0] ln;
      l = int'($urandom % 3);
      ln = (l == 0) ? 2'b00 : ((l == 1) ? 2'b01 : 2'b10);
      run_cycle(1'($urandom % 2), ln, 16'($urandom), 16'($urandom), int'($urandom % 7));
      repeat (int'($urandom % 4)) @(negedge clk);
    end
    check(proto_err == 0, "R9/R10 no error on clean traffic", proto_err, 0);

    // R8 aborted cycle
    @(negedge clk); strb_n = 1'b0; slow_sel_n = 1'b0; rd_wr = 1'b1;
    repeat (2) @(negedge clk);
    strb_n = 1'b1; slow_sel_n = 1'b1;
    seen_cs = 0; seen_done = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (!per_cs_n) seen_cs = 1;
      if (cyc_done) seen_done = 1;
    end
    check(!seen_cs && !seen_done, "R8 abort no select/done", {seen_cs, seen_done}, 0);

    // R10 release one clock late is allowed
    @(negedge clk); strb_n = 1'b0; slow_sel_n = 1'b0;
    @(negedge clk); strb_n = 1'b1;
    @(negedge clk); slow_sel_n = 1'b1;
    @(negedge clk);
    check(proto_err == 0, "R10 one-clock grace", proto_err, 0);

    // R10 release two clocks late flags
    @(negedge clk); strb_n = 1'b0; slow_sel_n = 1'b0;
    @(negedge clk); strb_n = 1'b1;
    @(negedge clk);
    check(proto_err == 0, "R10 not yet late", proto_err, 0);
    @(negedge clk);
    check(proto_err == 1, "R10 late release flagged", proto_err, 1);
    slow_sel_n = 1'b1;
    repeat (5) @(negedge clk);
    check(proto_err == 1, "R11 error sticky", proto_err, 1);

    // R9 acknowledge with select
    do_reset();
    @(negedge clk);
    check(proto_err == 0, "R2 error cleared by reset", proto_err, 0);
    strb_n = 1'b0; slow_sel_n = 1'b0; fast_ack_n = 1'b0;
    @(negedge clk);
    check(proto_err == 1, "R9 ack clash flagged", proto_err, 1);
    strb_n = 1'b1; slow_sel_n = 1'b1; fast_ack_n = 1'b1;
    repeat (4) @(negedge clk);
    check(proto_err == 1, "R11 sticky after clash", proto_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule